// File: doc/BRIEF.md
# Maskable Interrupt Register Block

This block gathers eight single-cycle event strobes from a serial bus controller and keeps each of them as a sticky bit in a status register. Each bit is qualified by a per-source enable mask. A single global gate then decides whether any qualified bit drives the one interrupt line to the processor. Software clears a status bit by writing a one to that bit position. Writing zero to a position leaves that bit as it was.

The same word-wide register port also carries a reset trigger. Writing a fixed key value to the trigger register produces a one-cycle reset pulse for the rest of the controller. The same pulse empties the status and enable registers. Registers are selected by byte offset. Writes take effect at the clock edge, and reads are combinational from the current register contents.

Top module: `irq_regblock`

## Requirements
- R1: An event strobe on `evt_i[k]` sets status bit k at the next clock edge. Bit positions are: 0 arbitration lost, 1 transmit error or transfer complete, 2 transmit empty, 3 receive level reached, 4 bus idle, 5 selected as target, 6 deselected as target, 7 transmit half empty.
- R2: Status bits are sticky. A write to offset 0x20 clears each status bit whose data bit is 1 and leaves each bit whose data bit is 0 unchanged. A read of 0x20 returns the status in bits 7:0, with zeros above.
- R3: When an event and a clearing write hit the same status bit in the same cycle, that bit stays set.
- R4: The enable mask at offset 0x28 stores data bits 7:0 on a write. It reads back in bits 7:0, with zeros above.
- R5: The global gate at offset 0x1C stores only data bit 31. All other data bits are ignored and read back as zero. While the gate is 0, `irq_o` is 0.
- R6: `irq_o` is 1 exactly when the gate is 1 and at least one status bit is set whose enable bit is also set. It follows a register change in the cycle after the edge that made the change.
- R7: A write of the value 0x0000000A to offset 0x40 raises `ctrl_rst_o` for exactly the one cycle after the write edge. At that same edge it clears the status and enable registers, which overrides any event in that cycle. The gate keeps its value.
- R8: A write to offset 0x40 with any other value has no effect: no pulse, and status, enable and gate are unchanged.
- R9: After reset, all registers are 0 and `irq_o` and `ctrl_rst_o` are 0. Reads of offset 0x40 and of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | N_SRC (8) | Event strobes, one per source |
| wr_en | input | 1 | Write strobe for the register port |
| addr | input | ADDR_W (8) | Byte offset of the register accessed |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Read data for `addr` |
| irq_o | output | 1 | Interrupt request |
| ctrl_rst_o | output | 1 | One-cycle reset pulse to the controller |

## Verification
The bench builds the block with its default parameters: eight sources, a 32-bit data word and an 8-bit offset. With eight sources, every source bit can be walked one at a time. The 32-bit word places the gate at bit 31, so writes that set every bit except the gate show that only that one bit counts. The key-comparison cases are also within reach: a key pattern at the wrong position, an extra bit set, and the exact key. A pseudo-random phase mixes events, clears, mask writes and key writes, and it is checked cycle by cycle against a behavioural model.

// File: rtl/irq_regblock.sv
module irq_regblock #(
  parameter int unsigned N_SRC  = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] GATE_OFS = 'h1C,
  parameter logic [ADDR_W-1:0] STAT_OFS = 'h20,
  parameter logic [ADDR_W-1:0] MASK_OFS = 'h28,
  parameter logic [ADDR_W-1:0] KICK_OFS = 'h40,
  parameter logic [DATA_W-1:0] KICK_KEY = 'hA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  evt_i,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq_o,
  output logic              ctrl_rst_o
);
  localparam int unsigned GATE_BIT = DATA_W - 1;
  localparam int unsigned PAD_W    = DATA_W - N_SRC;

  logic [N_SRC-1:0] status_q, enable_q, clr_mask;
  logic             gate_q;
  logic             wr_stat, wr_mask, wr_gate, kick;

  assign wr_stat  = wr_en && (addr == STAT_OFS);
  assign wr_mask  = wr_en && (addr == MASK_OFS);
  assign wr_gate  = wr_en && (addr == GATE_OFS);
  assign kick     = wr_en && (addr == KICK_OFS) && (wdata == KICK_KEY);
  assign clr_mask = wr_stat ? wdata[N_SRC-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q   <= '0;
      enable_q   <= '0;
      gate_q     <= 1'b0;
      ctrl_rst_o <= 1'b0;
    end else begin
      ctrl_rst_o <= kick;
      if (wr_gate) gate_q <= wdata[GATE_BIT];
      if (kick) begin
        status_q <= '0;
        enable_q <= '0;
      end else begin
        status_q <= (status_q & ~clr_mask) | evt_i;
        if (wr_mask) enable_q <= wdata[N_SRC-1:0];
      end
    end
  end

  assign irq_o = gate_q && |(status_q & enable_q);

  always_comb begin
    rdata = '0;
    if (addr == STAT_OFS)      rdata = {{PAD_W{1'b0}}, status_q};
    else if (addr == MASK_OFS) rdata = {{PAD_W{1'b0}}, enable_q};
    else if (addr == GATE_OFS) rdata[GATE_BIT] = gate_q;
  end
endmodule

module irq_regblock_chk #(
  parameter int unsigned N_SRC  = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] STAT_OFS = 'h20,
  parameter logic [ADDR_W-1:0] KICK_OFS = 'h40,
  parameter logic [DATA_W-1:0] KICK_KEY = 'hA
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_SRC-1:0]  evt_i,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic              irq_o,
  input logic              ctrl_rst_o,
  input logic [N_SRC-1:0]  status_q,
  input logic [N_SRC-1:0]  enable_q,
  input logic              gate_q
);
  logic key_wr, stat_wr;
  assign key_wr  = wr_en && addr == KICK_OFS && wdata == KICK_KEY;
  assign stat_wr = wr_en && addr == STAT_OFS;

  assert_latch_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !key_wr |=> (status_q & $past(evt_i)) == $past(evt_i));

  assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!key_wr && !stat_wr) |=> (status_q & $past(status_q)) == $past(status_q));

  assert_gate_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_q |-> !irq_o);

  assert_pulse_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rst_o |-> $past(key_wr));

  assert_pulse_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rst_o |-> (status_q == '0 && enable_q == '0));

  assert_bad_key_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == KICK_OFS && wdata != KICK_KEY) |=> !ctrl_rst_o);
endmodule

bind irq_regblock irq_regblock_chk #(
  .N_SRC(N_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
  .STAT_OFS(STAT_OFS), .KICK_OFS(KICK_OFS), .KICK_KEY(KICK_KEY)
) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .wr_en(wr_en), .addr(addr),
  .wdata(wdata), .irq_o(irq_o), .ctrl_rst_o(ctrl_rst_o),
  .status_q(status_q), .enable_q(enable_q), .gate_q(gate_q)
);

// File: tb/irq_regblock_tb.sv
module irq_regblock_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  evt_i = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_o, ctrl_rst_o;

  int n_run = 0, n_fail = 0;
  logic [7:0] m_stat = '0, m_en = '0;
  bit m_gate = 0, m_pulse = 0;
  bit model_on = 0;

  always #5 clk = ~clk;

  irq_regblock u_dut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_o(irq_o), .ctrl_rst_o(ctrl_rst_o)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // model update happens at the negedge following the edge that used the inputs
  always @(negedge clk) begin
    if (model_on) begin
      bit key;
      key = wr_en && addr == 8'h40 && wdata == 32'hA;
      m_pulse = key;
      if (wr_en && addr == 8'h1C) m_gate = wdata[31];
      if (key) begin
        m_stat = '0; m_en = '0;
      end else begin
        m_stat = (m_stat & ~((wr_en && addr == 8'h20) ? wdata[7:0] : 8'h00)) | evt_i;
        if (wr_en && addr == 8'h28) m_en = wdata[7:0];
      end
      chk("R6 irq", {31'd0, irq_o}, {31'd0, m_gate && ((m_stat & m_en) != 0)});
      chk("R7 pulse", {31'd0, ctrl_rst_o}, {31'd0, m_pulse});
    end
  end

  task automatic idle();
    wr_en = 0; evt_i = '0;
  endtask

  task automatic tick(); @(negedge clk); #1; endtask

  task automatic wr(logic [7:0] a, logic [31:0] d, logic [7:0] e = 8'h00);
    wr_en = 1; addr = a; wdata = d; evt_i = e;
    tick();
    idle();
  endtask

  task automatic rd(string req, logic [7:0] a, logic [31:0] exp);
    idle(); addr = a; #1;
    chk(req, rdata, exp);
  endtask

  task automatic pulse_evt(logic [7:0] e);
    evt_i = e; tick(); idle();
  endtask

  initial begin
    #200000;
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] lfsr;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    rd("R9 status", 8'h20, 0);
    rd("R9 enable", 8'h28, 0);
    rd("R9 gate", 8'h1C, 0);
    rd("R9 kick reg", 8'h40, 0);
    rd("R9 unmapped", 8'h24, 0);
    chk("R9 irq", {31'd0, irq_o}, 0);
    chk("R9 pulse", {31'd0, ctrl_rst_o}, 0);
    model_on = 1;
    tick();

    // R1: walk every source bit
    for (int k = 0; k < 8; k++) begin
      pulse_evt(8'(1 << k));
      rd("R1 latch", 8'h20, 32'(m_stat));
      chk("R1 bit", {31'd0, rdata[k]}, 1);
      wr(8'h20, 32'hFF);
    end
    // R2: sticky, write-one clear, write-zero keep
    pulse_evt(8'hA5);
    tick(); tick();
    rd("R2 sticky", 8'h20, 32'hA5);
    wr(8'h20, 32'h0000_0000);
    rd("R2 zero write", 8'h20, 32'hA5);
    wr(8'h20, 32'hFFFF_FF01);
    rd("R2 clear bit0", 8'h20, 32'hA4);
    // R3: event with clear on same bit
    wr(8'h20, 32'h0000_0008, 8'h08);
    rd("R3 set wins", 8'h20, 32'hA4 | 32'h08);
    // R4: enable mask
    wr(8'h28, 32'hFFFF_FF3C);
    rd("R4 enable", 8'h28, 32'h3C);
    // R5: gate
    wr(8'h1C, 32'h7FFF_FFFF);
    rd("R5 gate ignores low bits", 8'h1C, 0);
    chk("R5 irq low", {31'd0, irq_o}, 0);
    wr(8'h1C, 32'h8000_0000);
    rd("R5 gate set", 8'h1C, 32'h8000_0000);
    chk("R6 irq high", {31'd0, irq_o}, 1);
    wr(8'h28, 32'h0000_0010);
    chk("R6 masked", {31'd0, irq_o}, 0);
    pulse_evt(8'h10);
    chk("R6 pending", {31'd0, irq_o}, 1);
    // R8: wrong keys
    wr(8'h40, 32'h0000_0005);
    wr(8'h40, 32'h0000_001A);
    wr(8'h40, 32'hA000_0000);
    chk("R8 no pulse", {31'd0, ctrl_rst_o}, 0);
    rd("R8 status kept", 8'h20, 32'hBC);
    rd("R8 enable kept", 8'h28, 32'h10);
    rd("R8 gate kept", 8'h1C, 32'h8000_0000);
    // R7: good key with a concurrent event
    wr(8'h40, 32'h0000_000A, 8'h01);
    chk("R7 pulse high", {31'd0, ctrl_rst_o}, 1);
    rd("R7 status cleared", 8'h20, 0);
    rd("R7 enable cleared", 8'h28, 0);
    rd("R7 gate kept", 8'h1C, 32'h8000_0000);
    tick();
    chk("R7 pulse one cycle", {31'd0, ctrl_rst_o}, 0);

    // mixed traffic against the model
    lfsr = 32'h1234_5678;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      evt_i = (lfsr[3:0] == 0) ? lfsr[15:8] : 8'h00;
      wr_en = lfsr[16];
      case (lfsr[18:17])
        2'd0: addr = 8'h20;
        2'd1: addr = 8'h28;
        2'd2: addr = 8'h1C;
        default: addr = 8'h40;
      endcase
      wdata = (addr == 8'h40 && lfsr[19]) ? 32'hA : lfsr;
      tick();
      idle();
      rd("R2 status model", 8'h20, 32'(m_stat));
      rd("R4 enable model", 8'h28, 32'(m_en));
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule